// File: doc/BRIEF.md
# Shared-Pin Parallel GPIO Port

This block is a fifteen-pin general-purpose I/O port whose pins are shared with an external parallel host-transfer function. A processor reaches it over a simple single-cycle register bus that selects one of three words: a mode word, a direction word and a pin-value word. The pins behave as general-purpose I/O only while the two-bit mode field is zero. In that state, each direction bit decides whether its pin is driven, and the value word supplies driven levels or returns sampled ones.

When the mode field is non-zero, the pins belong to the alternate function. The block then passes that function's per-pin drive enables and values straight through to the tri-state pin controls. It keeps accepting writes to its own words, so software can prepare a GPIO setup before it takes the pins back. Pin inputs are always captured through a two-stage synchronizer before software can read them.

The register bus is a plain strobe interface. There is no back-pressure: every access completes in the cycle in which `bus_sel` is high. Read data is combinational during a read strobe and is zero at all other times.

Top module: `gpio_port_shared`

## Requirements
- R1: After reset the mode, direction and value words are all zero, `pin_oe` is all zero and `pin_out` is all zero.
- R2: The mode word at address 0xFFEC stores bus bits 1:0 as the mode field. A read returns that field in bits 1:0 and zeros in bits 15:2.
- R3: The direction word sits at address 0xFFED and the value word at 0xFFEE. A write strobe (`bus_sel`=1, `bus_wr`=1) updates the addressed word on that clock edge.
- R4: With mode field 0, `pin_oe[i]` equals direction bit i, where 1 means output and 0 means input.
- R5: With mode field 0, `pin_out[i]` equals value-word bit i.
- R6: With mode field 0, reading the value word returns, for each input pin, the level of `pin_in` from two rising clock edges earlier. A change is not yet visible after only one edge.
- R7: Reading the value word returns the stored bit, not the pin level, for each pin whose direction bit is 1.
- R8: With a non-zero mode field, `pin_oe` equals `alt_oe` and `pin_out` equals `alt_out`, whatever the direction and value words hold.
- R9: Writes to the direction and value words take effect in every mode. After the mode field returns to 0, the pins follow the values written while it was non-zero.
- R10: Bit 15 of the direction and value words always reads as 0, even after a write of 1.
- R11: A read of any address other than 0xFFEC to 0xFFEE returns 0, and a write to such an address changes no stored word.
- R12: `bus_rdata` is 0 whenever there is no read strobe (`bus_sel`=0 or `bus_wr`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during a read strobe |
| pin_in | input | 15 | Pad input levels (asynchronous) |
| pin_out | output | 15 | Pad output values |
| pin_oe | output | 15 | Pad output enables, 1 = drive |
| alt_out | input | 15 | Alternate function output values |
| alt_oe | input | 15 | Alternate function output enables |

## Verification
On every cycle, the checker holds the pad controls to the direction and value words in GPIO mode (R4, R5) and to the alternate inputs otherwise (R8). It also confirms that value-word writes land in every mode (R9), that reserved bits and idle read data stay zero (R10, R12), and that unmapped writes leave all words unchanged (R11). Only the bench scenarios can show the two-edge input latency (R6), the choice between stored value and pin level on readback (R7), and the mode-handover sequence in which values written during alternate mode appear on the pins once GPIO mode is restored.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MODE = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_VAL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 15,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS  = 15,
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] MODE_ADDR = 16'hFFEC,
  parameter logic [15:0] DIR_ADDR  = 16'hFFED,
  parameter logic [15:0] VAL_ADDR  = 16'hFFEE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [MODE_W-1:0]   mode_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] val_q
);
  reg_sel_e sel;
  logic     wr_en;
  logic     rd_en;
  logic [NUM_PINS-1:0] val_view;

  always_comb begin
    if (bus_addr == MODE_ADDR[ADDR_W-1:0])     sel = SEL_MODE;
    else if (bus_addr == DIR_ADDR[ADDR_W-1:0]) sel = SEL_DIR;
    else if (bus_addr == VAL_ADDR[ADDR_W-1:0]) sel = SEL_VAL;
    else                                       sel = SEL_NONE;
  end

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      val_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE: mode_q <= bus_wdata[MODE_W-1:0];
        SEL_DIR:  dir_q  <= bus_wdata[NUM_PINS-1:0];
        SEL_VAL:  val_q  <= bus_wdata[NUM_PINS-1:0];
        default:  ;
      endcase
    end
  end

  assign val_view = (val_q & dir_q) | (pin_sync & ~dir_q);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_MODE: bus_rdata[MODE_W-1:0]   = mode_q;
        SEL_DIR:  bus_rdata[NUM_PINS-1:0] = dir_q;
        SEL_VAL:  bus_rdata[NUM_PINS-1:0] = val_view;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 15
) (
  input  logic [MODE_W-1:0]   mode,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] val,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic gpio_mode;
  assign gpio_mode = (mode == '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_out[i] = gpio_mode ? val[i] : alt_out[i];
    assign pin_oe[i]  = gpio_mode ? dir[i] : alt_oe[i];
  end
endmodule

// File: rtl/gpio_port_shared.sv
module gpio_port_shared
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS    = 15,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MODE_ADDR   = 16'hFFEC,
  parameter logic [15:0] DIR_ADDR    = 16'hFFED,
  parameter logic [15:0] VAL_ADDR    = 16'hFFEE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [MODE_W-1:0]   mode_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] val_q;

  gpio_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(pin_sync)
  );

  gpio_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MODE_ADDR(MODE_ADDR),
    .DIR_ADDR (DIR_ADDR),
    .VAL_ADDR (VAL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_sync (pin_sync),
    .mode_q   (mode_q),
    .dir_q    (dir_q),
    .val_q    (val_q)
  );

  gpio_pin_mux #(
    .NUM_PINS(NUM_PINS)
  ) u_mux (
    .mode   (mode_q),
    .dir    (dir_q),
    .val    (val_q),
    .alt_out(alt_out),
    .alt_oe (alt_oe),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS  = 15,
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] MODE_ADDR = 16'hFFEC,
  parameter logic [15:0] DIR_ADDR  = 16'hFFED,
  parameter logic [15:0] VAL_ADDR  = 16'hFFEE
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] alt_out,
  input logic [NUM_PINS-1:0] alt_oe,
  input logic [MODE_W-1:0]   mode_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] val_q
);
  logic mapped;
  assign mapped = (bus_addr == MODE_ADDR[ADDR_W-1:0]) ||
                  (bus_addr == DIR_ADDR[ADDR_W-1:0])  ||
                  (bus_addr == VAL_ADDR[ADDR_W-1:0]);

  // R4
  gpio_oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == '0) |-> (pin_oe == dir_q));

  // R5
  gpio_out_follows_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == '0) |-> (pin_out == val_q));

  // R8
  alt_owns_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != '0) |-> (pin_oe == alt_oe && pin_out == alt_out));

  // R9
  val_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == VAL_ADDR[ADDR_W-1:0]) |=>
      (val_q == $past(bus_wdata[NUM_PINS-1:0])));

  // R10
  reserved_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1] == 1'b0);

  // R11
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !mapped) |=>
      ($stable(mode_q) && $stable(dir_q) && $stable(val_q)));

  // R12
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));
endmodule

bind gpio_port_shared gpio_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MODE_ADDR(MODE_ADDR),
  .DIR_ADDR (DIR_ADDR),
  .VAL_ADDR (VAL_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .alt_out  (alt_out),
  .alt_oe   (alt_oe),
  .mode_q   (mode_q),
  .dir_q    (dir_q),
  .val_q    (val_q)
);

// File: tb/test_gpio_port_shared.sv
module test_gpio_port_shared;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_MODE = 16'hFFEC;
  localparam logic [15:0] A_DIR  = 16'hFFED;
  localparam logic [15:0] A_VAL  = 16'hFFEE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [14:0] pin_in = '0;
  logic [14:0] pin_out;
  logic [14:0] pin_oe;
  logic [14:0] alt_out = '0;
  logic [14:0] alt_oe = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_port_shared i_gpio_port_shared (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; the write lands on the next rising edge.
  task automatic bus_write(logic [15:0] a, logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Combinational read with no clock edge in between.
  task automatic bus_peek(logic [15:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    bus_peek(A_MODE, r); check("R1 mode", r, 16'h0);
    bus_peek(A_DIR, r);  check("R1 dir", r, 16'h0);
    check("R1 pin_oe", {1'b0, pin_oe}, 16'h0);
    check("R1 pin_out", {1'b0, pin_out}, 16'h0);
  endtask

  task automatic t_mode_field();
    logic [15:0] r;
    bus_write(A_MODE, 16'hFFFF);
    bus_peek(A_MODE, r); check("R2 mode bits", r, 16'h0003);
    bus_write(A_MODE, 16'h0000);
    bus_peek(A_MODE, r); check("R2 mode clear", r, 16'h0000);
  endtask

  task automatic t_direction();
    logic [15:0] r;
    bus_write(A_DIR, 16'hFFFF);
    bus_peek(A_DIR, r); check("R10 dir bit15", r, 16'h7FFF);
    check("R4 all out", {1'b0, pin_oe}, 16'h7FFF);
    bus_write(A_DIR, 16'h00F0);
    bus_peek(A_DIR, r); check("R3 dir addr", r, 16'h00F0);
    check("R4 oe pattern", {1'b0, pin_oe}, 16'h00F0);
  endtask

  task automatic t_output();
    logic [15:0] r;
    bus_write(A_DIR, 16'h7FFF);
    bus_write(A_VAL, 16'hAA5A);
    check("R5 pin_out", {1'b0, pin_out}, 16'h2A5A);
    pin_in = ~15'h2A5A;
    repeat (3) @(negedge clk);
    bus_peek(A_VAL, r); check("R7 stored not pin", r, 16'h2A5A);
    check("R10 val bit15", {15'h0, r[15]}, 16'h0);
  endtask

  task automatic t_input_sync();
    logic [15:0] r;
    bus_write(A_DIR, 16'h0000);
    pin_in = 15'h0000;
    repeat (3) @(negedge clk);
    pin_in = 15'h1234;
    @(negedge clk);
    bus_peek(A_VAL, r); check("R6 one edge old", r, 16'h0000);
    @(negedge clk);
    bus_peek(A_VAL, r); check("R6 two edges new", r, 16'h1234);
  endtask

  task automatic t_mixed();
    logic [15:0] r;
    logic [14:0] d = 15'h00FF;
    logic [14:0] v = 15'h7F0F;
    logic [14:0] p = 15'h5555;
    bus_write(A_DIR, {1'b0, d});
    bus_write(A_VAL, {1'b0, v});
    pin_in = p;
    repeat (3) @(negedge clk);
    bus_peek(A_VAL, r);
    check("R7 mixed read", r, {1'b0, (v & d) | (p & ~d)});
  endtask

  task automatic t_alternate();
    logic [15:0] r;
    alt_oe = 15'h0F0F; alt_out = 15'h3333;
    bus_write(A_MODE, 16'h0002);
    check("R8 alt oe", {1'b0, pin_oe}, 16'h0F0F);
    check("R8 alt out", {1'b0, pin_out}, 16'h3333);
    bus_write(A_DIR, 16'h2222);
    bus_write(A_VAL, 16'h1111);
    check("R8 pins unchanged", {1'b0, pin_oe}, 16'h0F0F);
    bus_write(A_MODE, 16'h0000);
    check("R9 dir after return", {1'b0, pin_oe}, 16'h2222);
    check("R9 val after return", {1'b0, pin_out}, 16'h1111);
    bus_peek(A_DIR, r); check("R9 dir readback", r, 16'h2222);
  endtask

  task automatic t_unmapped();
    logic [15:0] r;
    bus_write(16'hFFEF, 16'hFFFF);
    bus_write(16'hFFEB, 16'hFFFF);
    bus_write(16'h0000, 16'hFFFF);
    bus_peek(16'hFFEF, r); check("R11 read FFEF", r, 16'h0);
    bus_peek(16'hFFEB, r); check("R11 read FFEB", r, 16'h0);
    bus_peek(A_MODE, r);   check("R11 mode kept", r, 16'h0);
    bus_peek(A_DIR, r);    check("R11 dir kept", r, 16'h2222);
    check("R11 val kept", {1'b0, pin_out}, 16'h1111);
  endtask

  task automatic t_idle();
    bus_sel = 1'b0; bus_addr = A_DIR; #1;
    check("R12 no strobe", bus_rdata, 16'h0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DIR; bus_wdata = 16'h2222; #1;
    check("R12 write strobe", bus_rdata, 16'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_field();
    t_direction();
    t_output();
    t_input_sync();
    t_mixed();
    t_alternate();
    t_unmapped();
    t_idle();
    done = 1'b1;
    finish_run();
  end
endmodule